// File: doc/BRIEF.md
# Receive Elastic Buffer with Slip Error

This block carries the receive byte stream and its data-valid qualifier from the clock recovered off the line into the local reference clock domain. The two clocks are nominally equal but may differ by a small fraction of a percent, so a small ring of entries absorbs the drift across one frame. At the start of every frame the reader waits until the ring is half full, giving equal headroom in both directions, and then streams one entry per read-enable cycle.

When the ring runs full or runs dry in the middle of a frame, no byte is silently lost or invented. The frame is instead tagged with a receive-error output that stays up until data-valid drops at the end of that frame. After each frame the ring drains to empty and the half-full start condition applies again to the next frame. The carrier-sense signal is not buffered. It passes straight through, so it tracks the line with no added delay.

Pointers cross the clock boundary in Gray code through two-flop synchronizers. An overflow seen on the write side travels to the read side as an error bit stored in the next entry written.

Top module: `rx_elastic_fifo`

## Requirements
- R1: While the read-side reset is low, `rd_dv`, `rd_er` and `rd_data` are all driven to zero from the next read clock edge.
- R2: A frame of at least DEPTH/2 bytes (8 by default) is not released at `rd_dv` before at least DEPTH/2 of its bytes have been written.
- R3: With `rd_en` held high and the write clock within 0.1% of the read clock, every byte of a frame appears on `rd_data` exactly once, in write order, with `rd_dv` high and `rd_er` low.
- R4: A frame shorter than DEPTH/2 bytes is released once its end has been written, and all of its bytes are delivered.
- R5: A read clock cycle with `rd_en` low leaves `rd_dv`, `rd_er` and `rd_data` unchanged.
- R6: If the ring is full when a byte of a frame arrives, the byte is dropped and `rd_er` is raised while that frame is still being delivered.
- R7: If `rd_en` finds the ring empty while a frame is being delivered, `rd_er` is raised and `rd_dv` stays high.
- R8: `rd_er` is only high while `rd_dv` is high. Once raised, it stays high until `rd_dv` falls, and it falls with it.
- R9: After a frame ends, the next frame again waits for the half-full condition, and it carries no error from the frame before it.
- R10: `crs_out` equals `crs_in` at all times, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_dv | input | 1 | Byte valid on the write side; high for the length of a frame |
| wr_data | input | 8 | Received byte on the write side |
| crs_in | input | 1 | Carrier sense from the line |
| rd_clk | input | 1 | Local reference clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Read step; one entry may advance per cycle with this high |
| rd_dv | output | 1 | Delayed data valid |
| rd_data | output | 8 | Delayed received byte; zero outside a frame |
| rd_er | output | 1 | Receive error for the frame in progress |
| crs_out | output | 1 | Unbuffered carrier sense |

## Verification
Clean frames are sent with counting bytes and with a scrambled byte sequence, with the write clock running slightly slow and slightly fast. A mismatch in either case points to an ordering or pointer-wrap fault rather than a data-path fault. A three-byte frame and a pair of frames separated by two idle cycles separate the half-full start rule from the end-of-frame start rule, and also test the re-arming between frames. An overflow is forced by holding the read step low mid-frame, and an underflow by halving the write clock rate. Each of these is followed by a clean frame, to show that the error flag is tied to one frame and is cleared when data-valid falls.

// File: rtl/rxe_pkg.sv
// Shared types and pointer code conversions for the receive elastic buffer.
// Assumes pointer widths never exceed 16 bits.
package rxe_pkg;

    // One ring entry: error marker, valid bit (0 = end-of-frame marker), byte.
    typedef struct packed {
        logic       err;
        logic       dv;
        logic [7:0] data;
    } rxe_entry_t;

    // Read-side sequencing states.
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_STREAM = 2'd1,
        RS_CLOSE  = 2'd2
    } rxe_rstate_t;

    // Binary to reflected Gray code.
    function automatic logic [15:0] bin_to_gray(input logic [15:0] b);
        return (b >> 1) ^ b;
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/rxe_sync2.sv
// Two-stage synchronizer for a Gray-coded pointer entering a clock domain.
// Assumes at most one bit of the input changes between source clock edges.
module rxe_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stage_q;

    // Two flops in series in the destination clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            d_out   <= '0;
        end else begin
            stage_q <= d_in;
            d_out   <= stage_q;
        end
    end

endmodule

// File: rtl/rxe_store.sv
// Entry storage for the ring: one write port in the write clock and two
// combinational read ports (head and newest entry) used by the read side.
// Assumes the read side only addresses entries whose write pointer it has
// already seen through the synchronizer.
module rxe_store
    import rxe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic       wr_clk,
    input  logic       we,
    input  logic [AW-1:0] waddr,
    input  rxe_entry_t wentry,
    input  logic [AW-1:0] haddr,
    output rxe_entry_t hentry,
    input  logic [AW-1:0] taddr,
    output rxe_entry_t tentry
);

    rxe_entry_t mem [DEPTH];

    // Write one entry per enabled write clock.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wentry;
        end
    end

    assign hentry = mem[haddr];
    assign tentry = mem[taddr];

endmodule

// File: rtl/rxe_wr_ctl.sv
// Write side of the elastic buffer. Stores each frame byte, adds an
// end-of-frame marker after the last one, and flags dropped bytes in the
// next entry that does get written. Assumes rgray_s is the read pointer
// already synchronized into wr_clk.
module rxe_wr_ctl
    import rxe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          wr_dv,
    input  logic [7:0]    wr_data,
    input  logic [PW-1:0] rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output rxe_entry_t    wentry,
    output logic [PW-1:0] wgray,
    output logic          full
);

    logic [PW-1:0] wbin;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] used;
    logic          in_frame_q;
    logic          term_pend_q;
    logic          ovf_pend_q;
    logic          do_term;
    logic          do_data;
    logic          dropped;

    assign rbin_s  = PW'(gray_to_bin(16'(rgray_s)));
    assign used    = wbin - rbin_s;
    assign full    = (used == PW'(DEPTH));
    // An end marker owed from a closed frame goes ahead of any new byte.
    assign do_term = term_pend_q || (!wr_dv && in_frame_q);
    assign do_data = wr_dv && !do_term;
    assign we      = (do_term || do_data) && !full;
    assign dropped = wr_dv && !(we && do_data);
    assign waddr   = wbin[AW-1:0];

    // Build the entry written this cycle.
    always_comb begin
        wentry.err  = ovf_pend_q;
        wentry.dv   = do_data;
        wentry.data = do_data ? wr_data : 8'h00;
    end

    // Pointer advance, pending marker and pending error bookkeeping.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin        <= '0;
            wgray       <= '0;
            in_frame_q  <= 1'b0;
            term_pend_q <= 1'b0;
            ovf_pend_q  <= 1'b0;
        end else begin
            in_frame_q <= wr_dv;
            if (we) begin
                wbin  <= PW'(wbin + 1'b1);
                wgray <= PW'(bin_to_gray(16'(PW'(wbin + 1'b1))));
            end
            if (do_term && we) begin
                term_pend_q <= 1'b0;
            end else if (do_term) begin
                term_pend_q <= 1'b1;
            end
            if (dropped) begin
                ovf_pend_q <= 1'b1;
            end else if (we) begin
                ovf_pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxe_rd_ctl.sv
// Read side of the elastic buffer. Waits for half fill (or a complete short
// frame), then advances one entry per rd_en cycle. Runs out of entries or
// stored error marks raise rd_er, which clears when rd_dv falls. Assumes
// wgray_s is the write pointer already synchronized into rd_clk.
module rxe_rd_ctl
    import rxe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5
) (
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray_s,
    input  rxe_entry_t    hentry,
    input  rxe_entry_t    tentry,
    output logic [AW-1:0] haddr,
    output logic [AW-1:0] taddr,
    output logic [PW-1:0] rgray,
    output logic [PW-1:0] fill,
    output logic          rd_dv,
    output logic          rd_er,
    output logic [7:0]    rd_data
);

    localparam int HALF = DEPTH / 2;

    rxe_rstate_t   state;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] tail;
    logic          empty;
    logic          start;
    logic          pop;

    assign wbin_s = PW'(gray_to_bin(16'(wgray_s)));
    assign fill   = wbin_s - rbin;
    assign empty  = (fill == '0);
    assign tail   = PW'(wbin_s - 1'b1);
    assign haddr  = rbin[AW-1:0];
    assign taddr  = tail[AW-1:0];
    // Release at the midpoint, or once a whole short frame is present.
    assign start  = (fill >= PW'(HALF)) || (!empty && !tentry.dv);
    assign pop    = rd_en && !empty &&
                    ((state == RS_STREAM) || (state == RS_IDLE && start));

    // Read pointer advance.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= PW'(rbin + 1'b1);
            rgray <= PW'(bin_to_gray(16'(PW'(rbin + 1'b1))));
        end
    end

    // Output sequencing across idle, streaming and error close-out.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            state   <= RS_IDLE;
            rd_dv   <= 1'b0;
            rd_er   <= 1'b0;
            rd_data <= 8'h00;
        end else if (rd_en) begin
            case (state)
                RS_IDLE: begin
                    if (pop && hentry.dv) begin
                        rd_dv   <= 1'b1;
                        rd_er   <= hentry.err;
                        rd_data <= hentry.data;
                        state   <= RS_STREAM;
                    end
                end
                RS_STREAM: begin
                    if (empty) begin
                        rd_er <= 1'b1;
                    end else if (hentry.dv) begin
                        rd_data <= hentry.data;
                        if (hentry.err) begin
                            rd_er <= 1'b1;
                        end
                    end else if (hentry.err) begin
                        rd_er <= 1'b1;
                        state <= RS_CLOSE;
                    end else begin
                        rd_dv   <= 1'b0;
                        rd_er   <= 1'b0;
                        rd_data <= 8'h00;
                        state   <= RS_IDLE;
                    end
                end
                RS_CLOSE: begin
                    rd_dv   <= 1'b0;
                    rd_er   <= 1'b0;
                    rd_data <= 8'h00;
                    state   <= RS_IDLE;
                end
                default: begin
                    state <= RS_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/rx_elastic_fifo.sv
// Receive elastic buffer top: write side in the recovered clock, read side
// in the reference clock, Gray pointers crossing through two-flop
// synchronizers. Carrier sense bypasses the ring. Assumes DEPTH is a power
// of two of at least 4.
module rx_elastic_fifo
    import rxe_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       wr_dv,
    input  logic [7:0] wr_data,
    input  logic       crs_in,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    input  logic       rd_en,
    output logic       rd_dv,
    output logic [7:0] rd_data,
    output logic       rd_er,
    output logic       crs_out
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          wr_we;
    logic          wr_full;
    logic [AW-1:0] wr_addr;
    rxe_entry_t    wr_entry;
    logic [PW-1:0] wgray;
    logic [PW-1:0] wgray_s;
    logic [PW-1:0] rgray;
    logic [PW-1:0] rgray_s;
    logic [AW-1:0] head_addr;
    logic [AW-1:0] tail_addr;
    rxe_entry_t    head_entry;
    rxe_entry_t    tail_entry;
    logic [PW-1:0] rd_fill;

    assign crs_out = crs_in;

    rxe_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_dv    (wr_dv),
        .wr_data  (wr_data),
        .rgray_s  (rgray_s),
        .we       (wr_we),
        .waddr    (wr_addr),
        .wentry   (wr_entry),
        .wgray    (wgray),
        .full     (wr_full)
    );

    rxe_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .wr_clk (wr_clk),
        .we     (wr_we),
        .waddr  (wr_addr),
        .wentry (wr_entry),
        .haddr  (head_addr),
        .hentry (head_entry),
        .taddr  (tail_addr),
        .tentry (tail_entry)
    );

    rxe_sync2 #(.W(PW)) u_sync_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (wgray),
        .d_out (wgray_s)
    );

    rxe_sync2 #(.W(PW)) u_sync_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d_in  (rgray),
        .d_out (rgray_s)
    );

    rxe_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .wgray_s  (wgray_s),
        .hentry   (head_entry),
        .tentry   (tail_entry),
        .haddr    (head_addr),
        .taddr    (tail_addr),
        .rgray    (rgray),
        .fill     (rd_fill),
        .rd_dv    (rd_dv),
        .rd_er    (rd_er),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/rx_elastic_fifo_chk.sv
// Property checker for the receive elastic buffer, bound into the top.
module rx_elastic_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic          rd_en,
    input logic          rd_dv,
    input logic          rd_er,
    input logic [7:0]    rd_data,
    input logic [PW-1:0] rd_fill
);

    logic rst_seen = 1'b0;

    // R1: one edge after reset is sampled low, the outputs are cleared.
    always @(posedge rd_clk) begin
        if (rst_seen) begin
            a_r1_reset_clears: assert (rd_dv == 1'b0 && rd_er == 1'b0 && rd_data == 8'h00);
        end
        rst_seen <= !rd_rst_n;
    end

    // R5: a cycle without rd_en leaves the outputs alone.
    a_r5_hold_without_en: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !rd_en |=> ($stable(rd_dv) && $stable(rd_er) && $stable(rd_data)));

    // R8: the error flag only appears inside a frame.
    a_r8_err_inside_frame: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_er |-> rd_dv);

    // R8: the error flag holds until valid falls.
    a_r8_err_sticky: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_er && rd_dv) |=> (rd_er || !rd_dv));

    // R3: the read side never sees more entries than the ring holds.
    a_r3_fill_bound: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_fill <= PW'(DEPTH));

endmodule

bind rx_elastic_fifo rx_elastic_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_dv    (rd_dv),
    .rd_er    (rd_er),
    .rd_data  (rd_data),
    .rd_fill  (rd_fill)
);

// File: tb/rx_elastic_fifo_tb.sv
`timescale 1ns/1ps
module rx_elastic_fifo_tb;

    localparam int DEPTH = 16;
    localparam int HALF  = DEPTH / 2;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_dv = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       crs_in = 1'b0;
    logic       rd_en = 1'b1;
    logic       rd_dv;
    logic [7:0] rd_data;
    logic       rd_er;
    logic       crs_out;

    real wr_half = 2.002;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    logic [7:0] exp_q[$];
    bit  sb_on = 1'b1;
    int  wr_cnt = 0;
    int  cur_len = 0;
    int  n_out = 0;
    bit  er_seen = 1'b0;
    bit  er_nodv = 1'b0;
    logic en_q = 1'b0;
    logic dv_last = 1'b0;

    always #2.0 rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    rx_elastic_fifo #(.DEPTH(DEPTH)) u_dut (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .wr_dv    (wr_dv),
        .wr_data  (wr_data),
        .crs_in   (crs_in),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_en    (rd_en),
        .rd_dv    (rd_dv),
        .rd_data  (rd_data),
        .rd_er    (rd_er),
        .crs_out  (crs_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: one byte per write clock, expected bytes queued when scored.
    task automatic send_frame(input int len, input bit scrambled, input bit push);
        @(negedge wr_clk);
        wr_cnt  = 0;
        cur_len = len;
        for (int i = 0; i < len; i++) begin
            wr_dv   = 1'b1;
            wr_data = scrambled ? 8'(i * 37 + 5) : 8'(i);
            if (push) exp_q.push_back(wr_data);
            wr_cnt++;
            @(negedge wr_clk);
        end
        wr_dv   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic drain();
        repeat (100) @(negedge rd_clk);
    endtask

    always @(posedge rd_clk) en_q <= rd_en;

    // Monitor: scores each newly produced byte and tracks error behaviour.
    always @(negedge rd_clk) begin
        if (rd_rst_n) begin
            if (rd_dv && !dv_last && cur_len >= HALF)
                chk(wr_cnt >= HALF, "R2", "bytes written before release", wr_cnt, HALF);
            if (rd_er && rd_dv) er_seen = 1'b1;
            if (rd_er && !rd_dv) er_nodv = 1'b1;
            if (en_q && rd_dv && sb_on) begin
                n_out++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected byte", rd_data, -1);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R3", "byte order", rd_data, e);
                    chk(!rd_er, "R3", "error on clean byte", rd_er, 0);
                end
            end
        end
        dv_last = rd_dv;
    end

    initial begin
        #(400us);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        logic [7:0] held;
        repeat (6) @(negedge rd_clk);
        // R1: reset state
        chk(rd_dv == 1'b0, "R1", "rd_dv in reset", rd_dv, 0);
        chk(rd_er == 1'b0, "R1", "rd_er in reset", rd_er, 0);
        chk(rd_data == 8'h00, "R1", "rd_data in reset", rd_data, 0);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (4) @(negedge rd_clk);

        // R10: carrier sense pass-through
        for (int i = 0; i < 4; i++) begin
            crs_in = i[0];
            #0.5;
            chk(crs_out == crs_in, "R10", "crs_out", crs_out, crs_in);
        end
        crs_in = 1'b0;

        // R3: counting bytes, write clock slightly slow
        send_frame(40, 1'b0, 1'b1);
        drain();
        chk(exp_q.size() == 0, "R3", "bytes left undelivered", exp_q.size(), 0);

        // R3: scrambled bytes, write clock slightly fast
        wr_half = 1.998;
        crs_in = 1'b1;
        send_frame(30, 1'b1, 1'b1);
        #0.3;
        chk(crs_out == 1'b1, "R10", "crs_out during frame", crs_out, 1);
        crs_in = 1'b0;
        drain();
        chk(exp_q.size() == 0, "R3", "bytes left undelivered", exp_q.size(), 0);

        // R4: short frame released at its end
        base = n_out;
        send_frame(3, 1'b1, 1'b1);
        drain();
        chk(n_out - base == 3, "R4", "short frame bytes delivered", n_out - base, 3);
        chk(rd_dv == 1'b0, "R4", "rd_dv after short frame", rd_dv, 0);

        // R9: back-to-back frames with re-arm between them
        send_frame(20, 1'b0, 1'b1);
        @(negedge wr_clk);
        send_frame(24, 1'b1, 1'b1);
        drain();
        chk(exp_q.size() == 0, "R9", "bytes left after back-to-back", exp_q.size(), 0);

        // R5, R6, R8: overflow by stalling the reader
        sb_on = 1'b0;
        er_seen = 1'b0;
        er_nodv = 1'b0;
        fork
            send_frame(60, 1'b1, 1'b0);
            begin
                wait (rd_dv == 1'b1);
                repeat (4) @(negedge rd_clk);
                held = rd_data;
                rd_en = 1'b0;
                for (int i = 0; i < 30; i++) begin
                    @(negedge rd_clk);
                    if (i < 4) begin
                        chk(rd_data == held, "R5", "rd_data held", rd_data, held);
                        chk(rd_dv == 1'b1, "R5", "rd_dv held", rd_dv, 1);
                    end
                end
                rd_en = 1'b1;
            end
        join
        drain();
        chk(er_seen, "R6", "overflow error seen in frame", er_seen, 1);
        chk(!er_nodv, "R8", "error outside frame", er_nodv, 0);
        chk(rd_er == 1'b0, "R8", "rd_er after frame", rd_er, 0);
        chk(rd_dv == 1'b0, "R8", "rd_dv after frame", rd_dv, 0);

        // R9: clean frame after an error frame
        exp_q.delete();
        sb_on = 1'b1;
        er_seen = 1'b0;
        send_frame(20, 1'b0, 1'b1);
        drain();
        chk(!er_seen, "R9", "error carried into next frame", er_seen, 0);
        chk(exp_q.size() == 0, "R9", "bytes left undelivered", exp_q.size(), 0);

        // R7, R8: underflow with a write clock at half rate
        wr_half = 4.0;
        sb_on = 1'b0;
        er_seen = 1'b0;
        er_nodv = 1'b0;
        send_frame(40, 1'b0, 1'b0);
        drain();
        chk(er_seen, "R7", "underflow error seen in frame", er_seen, 1);
        chk(!er_nodv, "R8", "error outside frame", er_nodv, 0);
        chk(rd_er == 1'b0, "R8", "rd_er after frame", rd_er, 0);

        // R9: clean again at nominal rate
        wr_half = 2.0;
        exp_q.delete();
        sb_on = 1'b1;
        er_seen = 1'b0;
        send_frame(25, 1'b1, 1'b1);
        drain();
        chk(!er_seen, "R9", "error after underflow frame", er_seen, 0);
        chk(exp_q.size() == 0, "R3", "bytes left undelivered", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule